// File: doc/BRIEF.md
# Dual Parallel Port Adapter with Handshake Lines

This block gives a processor two 8-bit parallel ports, A and B, through four byte-wide register locations. Each port has an output register, a direction register (a 1 bit makes the matching pin an output) and a control register. The control register sets up two handshake lines per port. Handshake line 1 is always an input. Handshake line 2 is either an input or an output. Edges on these lines set interrupt flags, and each flag can be enabled onto the port's interrupt output.

The register interface is a single-clock synchronous strobe interface. It has no valid/ready flow control and no back-pressure. Every access completes in the cycle its strobe is high. Read data is combinational from the current state during that cycle. Side effects of the access take effect at the closing clock edge. `bus_rd` and `bus_wr` are never high in the same cycle.

Register locations are selected by `bus_sel`:
- 0: port A data or direction
- 1: port A control
- 2: port B data or direction
- 3: port B control

Control register bit fields:
- bit 0: line-1 interrupt enable
- bit 1: line-1 active edge (1 = rising, 0 = falling)
- bit 2: data-location target (1 = output register, 0 = direction register)
- bit 3: line-2 input mode: interrupt enable; set/reset mode: level to drive; strobe mode: early-return option
- bit 4: line-2 input mode: active edge (1 = rising); output mode: 1 = set/reset, 0 = strobe
- bit 5: line-2 is an output
- bit 6: line-2 flag (read-only)
- bit 7: line-1 flag (read-only)

Top module: `pio_dual_port`

## Requirements
- R1: Register locations and targets.
  - Select code 0 is A data, 1 is A control, 2 is B data and 3 is B control.
  - At a data location, control bit 2 = 1 accesses the output register and bit 2 = 0 accesses the direction register.
  - Output pins carry the output register ANDed with the direction register. The direction register appears on the direction pins.
- R2: A data read with bit 2 = 1 returns output-register bits where the direction bit is 1 and input-pin bits where it is 0.
- R3: A control write stores only bits 5..0. Bits 7..6 read back as the flags and are not changed by the write.
- R4: Read-to-clear rules.
  - A port A data read with bit 2 = 1 clears bit 7 in both control registers.
  - A port B data read with bit 2 = 1 clears bit 6 in both control registers.
  - Interrupt outputs follow from the next cycle.
  - Direction-register reads clear nothing.
- R5: Line-1 flag.
  - A line-1 edge matching control bit 1 (1 = rising, 0 = falling) sets bit 7. A non-matching edge does not.
  - If the edge falls in the same cycle as a clearing read, the flag ends set.
- R6: Line-2 flag.
  - With line 2 an input (bit 5 = 0), an edge matching bit 4 (1 = rising, 0 = falling) sets bit 6.
  - A non-matching edge does not set bit 6.
- R7: A port's interrupt output is high while (bit 7 AND bit 0) OR (bit 6 AND bit 3 AND NOT bit 5).
- R8: A control write with bits 5 and 4 both 1 drives line 2 to the written bit 3 from the next cycle. The line-2 output-enable follows bit 5.
- R9: Strobe mode (bits 5 = 1, 4 = 0).
  - A port A data read with bit 2 = 1 drives A line 2 low.
  - A port B data write with bit 2 = 1 drives B line 2 low.
  - A port B data read does not.
  - With bit 3 = 1 the line returns high one cycle later.
- R10: In strobe mode with bit 3 = 0, line 2 stays low until the next active line-1 edge, then returns high.
- R11: While line 2 is an output, bit 6 reads 0, line-2 activity sets no flag, and bit 6 adds nothing to the interrupt.
- R12: After reset, all registers read 0, all pins are inputs, both line-2 outputs are high and both interrupts are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 2 | Register location select |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | W | Write data |
| bus_rdata | output | W | Read data |
| pa_in | input | W | Port A pin inputs |
| pa_out | output | W | Port A pin drive values |
| pa_dir | output | W | Port A pin output enables |
| pa_hs1 | input | 1 | Port A handshake line 1 |
| pa_hs2_in | input | 1 | Port A handshake line 2 input |
| pa_hs2_out | output | 1 | Port A handshake line 2 drive level |
| pa_hs2_oe | output | 1 | Port A handshake line 2 output enable |
| irq_a | output | 1 | Port A interrupt request |
| pb_in | input | W | Port B pin inputs |
| pb_out | output | W | Port B pin drive values |
| pb_dir | output | W | Port B pin output enables |
| pb_hs1 | input | 1 | Port B handshake line 1 |
| pb_hs2_in | input | 1 | Port B handshake line 2 input |
| pb_hs2_out | output | 1 | Port B handshake line 2 drive level |
| pb_hs2_oe | output | 1 | Port B handshake line 2 output enable |
| irq_b | output | 1 | Port B interrupt request |

## Verification
A flag can be set by a handshake edge and cleared by a data read in the same cycle. The bench provokes this by raising port A line 1 on the same clock edge as a port A output-register read. It then reads control A back and requires bit 7 to still be set. The strobe-mode line-2 drop and its early return can also coincide with a fresh trigger. The bench judges these cases from the line-2 pin value one and two cycles after the access.

// File: rtl/pio_pkg.sv
package pio_pkg;
  // control register field positions
  localparam int CB_HS1_IE   = 0;
  localparam int CB_HS1_RISE = 1;
  localparam int CB_DATA_SEL = 2;
  localparam int CB_HS2_B3   = 3;
  localparam int CB_HS2_B4   = 4;
  localparam int CB_HS2_OUT  = 5;

  typedef enum logic [1:0] {
    SEL_A_DATA = 2'd0,
    SEL_A_CTL  = 2'd1,
    SEL_B_DATA = 2'd2,
    SEL_B_CTL  = 2'd3
  } sel_e;
endpackage

// File: rtl/pio_edge.sv
module pio_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  input  logic rise_sel,
  output logic hit
);
  logic prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= lvl;
  end

  // an active edge: level changed and the new level matches the chosen polarity
  assign hit = (lvl != prev_q) && (lvl == rise_sel);
endmodule

// File: rtl/pio_hs2_drive.sv
module pio_hs2_drive (
  input  logic clk,
  input  logic rst_n,
  input  logic out_mode,
  input  logic pulse_mode,
  input  logic auto_restore,
  input  logic load,
  input  logic load_val,
  input  logic trigger,
  input  logic hs1_hit,
  output logic level
);
  always_ff @(posedge clk) begin
    if (!rst_n)
      level <= 1'b1;
    else if (load)
      level <= load_val;
    else if (trigger && out_mode && pulse_mode)
      level <= 1'b0;
    else if (out_mode && pulse_mode && !level && (auto_restore || hs1_hit))
      level <= 1'b1;
  end

  // R8: a set/reset load lands on the line one cycle later
  a_r8_load_level: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (level == $past(load_val)));

  // R9: a strobe trigger pulls the line low
  a_r9_strobe_low: assert property (@(posedge clk) disable iff (!rst_n)
    (trigger && out_mode && pulse_mode && !load) |=> !level);

  // R9: early-return option releases the line after one low cycle
  a_r9_early_return: assert property (@(posedge clk) disable iff (!rst_n)
    (!level && out_mode && pulse_mode && auto_restore && !trigger && !load) |=> level);
endmodule

// File: rtl/pio_port.sv
module pio_port import pio_pkg::*; #(
  parameter int W = 8,
  parameter bit STROBE_ON_WRITE = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         acc_data_rd,
  input  logic         acc_data_wr,
  input  logic         acc_ctl_wr,
  input  logic [W-1:0] wdata,
  input  logic         clr_hs1_flag,
  input  logic         clr_hs2_flag,
  input  logic [W-1:0] pin_in,
  input  logic         hs1_in,
  input  logic         hs2_in,
  output logic [W-1:0] data_view,
  output logic [W-1:0] ctl_view,
  output logic [W-1:0] pin_out,
  output logic [W-1:0] pin_dir,
  output logic         hs2_out,
  output logic         hs2_oe,
  output logic         irq
);
  localparam int CW = W - 2;

  logic [W-1:0]  or_q, dir_q;
  logic [CW-1:0] ctl_q;
  logic          f1_q, f2_q;
  logic          hs1_hit, hs2_hit, trigger;
  logic          out_sel, hs2_is_out;

  assign out_sel    = ctl_q[CB_DATA_SEL];
  assign hs2_is_out = ctl_q[CB_HS2_OUT];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      or_q  <= '0;
      dir_q <= '0;
      ctl_q <= '0;
    end else begin
      if (acc_data_wr && out_sel)  or_q  <= wdata;
      if (acc_data_wr && !out_sel) dir_q <= wdata;
      if (acc_ctl_wr)              ctl_q <= wdata[CW-1:0];
    end
  end

  pio_edge u_hs1_edge (
    .clk(clk), .rst_n(rst_n), .lvl(hs1_in),
    .rise_sel(ctl_q[CB_HS1_RISE]), .hit(hs1_hit)
  );

  pio_edge u_hs2_edge (
    .clk(clk), .rst_n(rst_n), .lvl(hs2_in),
    .rise_sel(ctl_q[CB_HS2_B4]), .hit(hs2_hit)
  );

  // a new edge wins over a clearing read in the same cycle
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      f1_q <= 1'b0;
      f2_q <= 1'b0;
    end else begin
      if (hs1_hit)           f1_q <= 1'b1;
      else if (clr_hs1_flag) f1_q <= 1'b0;
      if (hs2_hit && !hs2_is_out) f2_q <= 1'b1;
      else if (clr_hs2_flag)      f2_q <= 1'b0;
    end
  end

  generate
    if (STROBE_ON_WRITE) begin : g_wr_strobe
      assign trigger = acc_data_wr && out_sel;
    end else begin : g_rd_strobe
      assign trigger = acc_data_rd && out_sel;
    end
  endgenerate

  pio_hs2_drive u_hs2 (
    .clk(clk), .rst_n(rst_n),
    .out_mode(hs2_is_out),
    .pulse_mode(!ctl_q[CB_HS2_B4]),
    .auto_restore(ctl_q[CB_HS2_B3]),
    .load(acc_ctl_wr && wdata[CB_HS2_OUT] && wdata[CB_HS2_B4]),
    .load_val(wdata[CB_HS2_B3]),
    .trigger(trigger),
    .hs1_hit(hs1_hit),
    .level(hs2_out)
  );

  assign data_view = out_sel ? ((or_q & dir_q) | (pin_in & ~dir_q)) : dir_q;
  assign ctl_view  = {f1_q, f2_q & ~hs2_is_out, ctl_q};
  assign pin_out   = or_q & dir_q;
  assign pin_dir   = dir_q;
  assign hs2_oe    = hs2_is_out;
  assign irq = (f1_q & ctl_q[CB_HS1_IE]) |
               (f2_q & ctl_q[CB_HS2_B3] & ~hs2_is_out);

  // R5: an active line-1 edge leaves the flag set
  a_r5_hs1_sets: assert property (@(posedge clk) disable iff (!rst_n)
    hs1_hit |=> f1_q);

  // R4: a clearing read with no edge leaves the flag clear
  a_r4_clear_hs1: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_hs1_flag && !hs1_hit) |=> !f1_q);

  // R3: control writes do not touch the flags
  a_r3_flags_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_ctl_wr && !clr_hs1_flag && !hs1_hit) |=> (f1_q == $past(f1_q)));

  // R11: no line-2 flag is raised while line 2 is an output
  a_r11_no_hs2_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (hs2_is_out && !f2_q && !acc_ctl_wr) |=> !f2_q);
endmodule

// File: rtl/pio_dual_port.sv
module pio_dual_port import pio_pkg::*; #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [1:0]   bus_sel,
  input  logic         bus_rd,
  input  logic         bus_wr,
  input  logic [W-1:0] bus_wdata,
  output logic [W-1:0] bus_rdata,
  input  logic [W-1:0] pa_in,
  output logic [W-1:0] pa_out,
  output logic [W-1:0] pa_dir,
  input  logic         pa_hs1,
  input  logic         pa_hs2_in,
  output logic         pa_hs2_out,
  output logic         pa_hs2_oe,
  output logic         irq_a,
  input  logic [W-1:0] pb_in,
  output logic [W-1:0] pb_out,
  output logic [W-1:0] pb_dir,
  input  logic         pb_hs1,
  input  logic         pb_hs2_in,
  output logic         pb_hs2_out,
  output logic         pb_hs2_oe,
  output logic         irq_b
);
  localparam int NP = 2;

  sel_e sel;
  assign sel = sel_e'(bus_sel);

  logic [NP-1:0][W-1:0] data_v, ctl_v, pin_in_v, pin_out_v, pin_dir_v;
  logic [NP-1:0] hs1_v, hs2_in_v, hs2_out_v, hs2_oe_v, irq_v;
  logic          clr_hs1, clr_hs2;

  assign pin_in_v = {pb_in, pa_in};
  assign hs1_v    = {pb_hs1, pa_hs1};
  assign hs2_in_v = {pb_hs2_in, pa_hs2_in};

  // output-register reads clear flags in both ports
  assign clr_hs1 = bus_rd && (sel == SEL_A_DATA) && ctl_v[0][CB_DATA_SEL];
  assign clr_hs2 = bus_rd && (sel == SEL_B_DATA) && ctl_v[1][CB_DATA_SEL];

  generate
    for (genvar i = 0; i < NP; i++) begin : g_port
      localparam logic [1:0] DSEL = 2'(2 * i);
      localparam logic [1:0] CSEL = 2'(2 * i + 1);
      pio_port #(.W(W), .STROBE_ON_WRITE(i == 1)) u_port (
        .clk(clk), .rst_n(rst_n),
        .acc_data_rd(bus_rd && (bus_sel == DSEL)),
        .acc_data_wr(bus_wr && (bus_sel == DSEL)),
        .acc_ctl_wr(bus_wr && (bus_sel == CSEL)),
        .wdata(bus_wdata),
        .clr_hs1_flag(clr_hs1),
        .clr_hs2_flag(clr_hs2),
        .pin_in(pin_in_v[i]),
        .hs1_in(hs1_v[i]),
        .hs2_in(hs2_in_v[i]),
        .data_view(data_v[i]),
        .ctl_view(ctl_v[i]),
        .pin_out(pin_out_v[i]),
        .pin_dir(pin_dir_v[i]),
        .hs2_out(hs2_out_v[i]),
        .hs2_oe(hs2_oe_v[i]),
        .irq(irq_v[i])
      );
    end
  endgenerate

  always_comb begin
    unique case (sel)
      SEL_A_DATA: bus_rdata = data_v[0];
      SEL_A_CTL:  bus_rdata = ctl_v[0];
      SEL_B_DATA: bus_rdata = data_v[1];
      default:    bus_rdata = ctl_v[1];
    endcase
  end

  assign pa_out     = pin_out_v[0];
  assign pa_dir     = pin_dir_v[0];
  assign pa_hs2_out = hs2_out_v[0];
  assign pa_hs2_oe  = hs2_oe_v[0];
  assign irq_a      = irq_v[0];
  assign pb_out     = pin_out_v[1];
  assign pb_dir     = pin_dir_v[1];
  assign pb_hs2_out = hs2_out_v[1];
  assign pb_hs2_oe  = hs2_oe_v[1];
  assign irq_b      = irq_v[1];

  // R4: after a port A output read with no new line-1 edge, neither port keeps a line-1 interrupt
  a_r4_cross_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_hs1 && !bus_wr && $stable(pa_hs1) && $stable(pb_hs1)) |=> !ctl_v[0][W-1] && !ctl_v[1][W-1]);
endmodule

// File: tb/pio_dual_port_test.sv
module pio_dual_port_test;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] bus_sel = '0;
  logic bus_rd = 1'b0, bus_wr = 1'b0;
  logic [W-1:0] bus_wdata = '0, bus_rdata;
  logic [W-1:0] pa_in = '0, pa_out, pa_dir, pb_in = '0, pb_out, pb_dir;
  logic pa_hs1 = 1'b0, pa_hs2_in = 1'b0, pa_hs2_out, pa_hs2_oe, irq_a;
  logic pb_hs1 = 1'b0, pb_hs2_in = 1'b0, pb_hs2_out, pb_hs2_oe, irq_b;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  pio_dual_port #(.W(W)) uut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pa_in(pa_in), .pa_out(pa_out), .pa_dir(pa_dir), .pa_hs1(pa_hs1),
    .pa_hs2_in(pa_hs2_in), .pa_hs2_out(pa_hs2_out), .pa_hs2_oe(pa_hs2_oe), .irq_a(irq_a),
    .pb_in(pb_in), .pb_out(pb_out), .pb_dir(pb_dir), .pb_hs1(pb_hs1),
    .pb_hs2_in(pb_hs2_in), .pb_hs2_out(pb_hs2_out), .pb_hs2_oe(pb_hs2_oe), .irq_b(irq_b)
  );

  task automatic chk(string tag, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] s, logic [W-1:0] d);
    @(negedge clk);
    bus_sel = s; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(logic [1:0] s, output logic [W-1:0] v);
    @(negedge clk);
    bus_sel = s; bus_rd = 1'b1;
    #1 v = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sweep(int port);
    logic [1:0] ds, cs;
    logic [W-1:0] v;
    ds = 2'(2 * port);
    cs = 2'(2 * port + 1);
    for (int d = 0; d < 256; d++) begin
      logic [W-1:0] dv, o, p;
      dv = d[W-1:0];
      o  = dv ^ 8'hA5;
      p  = 8'(dv * 8'd3) ^ 8'h3C;
      wr(cs, 8'h00);
      wr(ds, dv);
      rd(ds, v);
      chk("R1 direction readback", v, dv);
      wr(cs, 8'h04);
      wr(ds, o);
      if (port == 0) pa_in = p; else pb_in = p;
      rd(ds, v);
      chk("R2 mixed data read", v, (o & dv) | (p & ~dv));
      chk("R1 pin drive", (port == 0) ? pa_out : pb_out, o & dv);
    end
    wr(cs, 8'h00);
    wr(ds, 8'h00);
  endtask

  initial begin : wdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : main
    logic [W-1:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R12 reset state
    for (int s = 0; s < 4; s++) begin
      rd(2'(s), v);
      chk("R12 reset register", v, 8'h00);
    end
    chk("R12 dir A", pa_dir, 8'h00);
    chk("R12 dir B", pb_dir, 8'h00);
    chk("R12 hs2 levels", {6'd0, pa_hs2_out, pb_hs2_out}, 8'h03);
    chk("R12 irqs", {6'd0, irq_a, irq_b}, 8'h00);

    // R1 R2 sweeps
    sweep(0);
    sweep(1);

    // R3 R8 control sweep on port B
    for (int c = 0; c < 64; c++) begin
      logic [W-1:0] cv;
      cv = 8'(c);
      wr(2'd3, 8'hC0 | cv);
      rd(2'd3, v);
      chk("R3 control readback", v, cv);
      chk("R8 hs2 oe", {7'd0, pb_hs2_oe}, {7'd0, cv[5]});
      if (cv[5] && cv[4]) chk("R8 set/reset level", {7'd0, pb_hs2_out}, {7'd0, cv[3]});
      chk("R7 no irq without flags", {7'd0, irq_b}, 8'h00);
    end
    wr(2'd3, 8'h00);

    // R5 R7 R4 line-1 flags and cross clear
    wr(2'd1, 8'h07);
    wr(2'd3, 8'h03);
    @(negedge clk); pa_hs1 = 1'b1; pb_hs1 = 1'b1;
    idle(1);
    chk("R7 irq A from line1", {7'd0, irq_a}, 8'h01);
    chk("R7 irq B from line1", {7'd0, irq_b}, 8'h01);
    rd(2'd1, v); chk("R5 flag A rising", v, 8'h87);
    rd(2'd3, v); chk("R5 flag B rising", v, 8'h83);
    rd(2'd0, v);
    chk("R4 irq A cleared", {7'd0, irq_a}, 8'h00);
    chk("R4 irq B cleared", {7'd0, irq_b}, 8'h00);
    rd(2'd3, v); chk("R4 cross clear B", v, 8'h03);
    @(negedge clk); pa_hs1 = 1'b0;
    idle(1);
    rd(2'd1, v); chk("R5 wrong edge ignored", v, 8'h07);
    wr(2'd1, 8'h05);
    @(negedge clk); pa_hs1 = 1'b1; idle(1);
    rd(2'd1, v); chk("R5 rising ignored in falling mode", v, 8'h05);
    @(negedge clk); pa_hs1 = 1'b0; idle(1);
    rd(2'd1, v); chk("R5 falling sets", v, 8'h85);
    chk("R7 irq falling", {7'd0, irq_a}, 8'h01);
    wr(2'd1, 8'h04);
    chk("R7 irq masked", {7'd0, irq_a}, 8'h00);
    rd(2'd1, v); chk("R3 flag kept over write", v, 8'h84);
    rd(2'd0, v);
    rd(2'd1, v); chk("R4 flag cleared", v, 8'h04);

    // R5 same-cycle edge and clearing read
    wr(2'd1, 8'h07);
    @(negedge clk);
    bus_sel = 2'd0; bus_rd = 1'b1; pa_hs1 = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    rd(2'd1, v); chk("R5 edge beats clear", v, 8'h87);
    rd(2'd0, v);
    rd(2'd1, v); chk("R4 later clear", v, 8'h07);
    @(negedge clk); pa_hs1 = 1'b0; idle(1);

    // R6 line-2 input flags
    wr(2'd1, 8'h1C);
    wr(2'd3, 8'h04);
    @(negedge clk); pa_hs2_in = 1'b1; idle(1);
    rd(2'd1, v); chk("R6 rising sets", v, 8'h5C);
    chk("R7 irq from line2", {7'd0, irq_a}, 8'h01);
    rd(2'd0, v);
    rd(2'd1, v); chk("R4 A read keeps bit6", v, 8'h5C);
    rd(2'd2, v);
    rd(2'd1, v); chk("R4 B read clears bit6", v, 8'h1C);
    chk("R7 irq line2 clear", {7'd0, irq_a}, 8'h00);
    @(negedge clk); pa_hs2_in = 1'b0; idle(1);
    rd(2'd1, v); chk("R6 falling ignored", v, 8'h1C);
    wr(2'd1, 8'h0C);
    @(negedge clk); pa_hs2_in = 1'b1; idle(1);
    @(negedge clk); pa_hs2_in = 1'b0; idle(1);
    rd(2'd1, v); chk("R6 falling sets", v, 8'h4C);
    rd(2'd2, v);

    // R11 line-2 output mode
    wr(2'd1, 8'h3C);
    chk("R8 level high", {7'd0, pa_hs2_out}, 8'h01);
    chk("R8 oe high", {7'd0, pa_hs2_oe}, 8'h01);
    @(negedge clk); pa_hs2_in = 1'b1; idle(1);
    @(negedge clk); pa_hs2_in = 1'b0; idle(1);
    rd(2'd1, v); chk("R11 no flag in output mode", v, 8'h3C);
    chk("R11 no irq", {7'd0, irq_a}, 8'h00);
    wr(2'd1, 8'h34);
    chk("R8 level low", {7'd0, pa_hs2_out}, 8'h00);
    wr(2'd1, 8'h1C);
    @(negedge clk); pa_hs2_in = 1'b1; idle(1);
    wr(2'd1, 8'h3C);
    rd(2'd1, v); chk("R11 bit6 masked", v, 8'h3C);
    chk("R11 irq masked", {7'd0, irq_a}, 8'h00);
    wr(2'd1, 8'h1C);
    rd(2'd1, v); chk("R11 flag kept under mask", v, 8'h5C);
    rd(2'd2, v);
    @(negedge clk); pa_hs2_in = 1'b0; idle(1);

    // R9 port A read strobe with early return
    wr(2'd1, 8'h3C);
    wr(2'd1, 8'h2C);
    chk("R9 idle high", {7'd0, pa_hs2_out}, 8'h01);
    rd(2'd0, v);
    chk("R9 A read strobe low", {7'd0, pa_hs2_out}, 8'h00);
    idle(1);
    chk("R9 A early return", {7'd0, pa_hs2_out}, 8'h01);

    // R10 strobe held until line-1 edge
    wr(2'd1, 8'h3C);
    wr(2'd1, 8'h26);
    rd(2'd0, v);
    chk("R10 strobe low", {7'd0, pa_hs2_out}, 8'h00);
    idle(3);
    chk("R10 still low", {7'd0, pa_hs2_out}, 8'h00);
    @(negedge clk); pa_hs1 = 1'b1; idle(1);
    chk("R10 released by line1", {7'd0, pa_hs2_out}, 8'h01);
    rd(2'd1, v); chk("R5 flag in strobe mode", v, 8'hA6);
    wr(2'd1, 8'h3C);
    @(negedge clk); pa_hs1 = 1'b0; idle(1);

    // R9 port B write strobe
    wr(2'd3, 8'h3C);
    wr(2'd3, 8'h2C);
    rd(2'd2, v);
    chk("R9 B read no strobe", {7'd0, pb_hs2_out}, 8'h01);
    wr(2'd2, 8'h11);
    chk("R9 B write strobe low", {7'd0, pb_hs2_out}, 8'h00);
    idle(1);
    chk("R9 B early return", {7'd0, pb_hs2_out}, 8'h01);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule